// File: doc/BRIEF.md
# Line Pixel Sequencer for a Serial CCD Digitizer

This block is the host-side timing engine for one line of a linear CCD fed through a serial-output digitizer. When the host asks for a line, it steps through a fixed pixel period measured in system-clock cycles. In each period it drives a black-level clamp strobe, then a sample strobe whose falling edge starts a conversion. After a quiet lead time it drives eight serial clock pulses. On each rising serial clock edge it captures one data bit, most significant bit first, and assembles a byte. Every pulse width and separation is a parameter counted in clock cycles.

The digitizer returns each result two sample strobes after the sample it belongs to. The sequencer therefore runs two extra flush periods after the last real pixel. It publishes only the bytes that belong to the current line, in sample order. The clamp runs in one of two ways. In correlated-double-sampling mode it fires in every real pixel period. In dark-reference mode it fires only in the first few periods of the line, as many as a programmed dark count allows.

Top module: `ccd_pixel_sequencer`

## Requirements
- R1: After reset, every strobe (`samp_o`, `clamp_o`, `sclk_o`), `word_valid_o`, `line_done_o` and `busy_o` are low.
- R2: A line of length L runs L+2 pixel periods of PIX_CYC cycles each (default 200). Each period has exactly one sample pulse, high for SAMP_W cycles (default 52), and consecutive sample rises are PIX_CYC cycles apart.
- R3: A clamp pulse is CLAMP_W cycles wide (default 32). It ends SEP_W cycles (default 6) before the sample pulse of the same period rises, and clamp and sample are never high together.
- R4: Each pixel period has exactly eight serial clock pulses, each high for HALF_W cycles (default 6). The first rising edge comes LEAD_W cycles (default 6) after the sample pulse falls.
- R5: The serial clock stays low while the sample pulse is high and in the cycle right after it falls.
- R6: One data bit is captured at each serial clock rise. The first bit captured after a sample fall becomes bit 7 of the byte and the eighth becomes bit 0.
- R7: `word_valid_o` is a one-cycle pulse, raised once in each of pixel periods 2 to L+1 (periods counted from 0). The byte in period p is the result of sample p-2, so a line gives exactly L bytes in sample order.
- R8: `line_done_o` pulses for one cycle when the last flush period ends. The block then goes idle with `busy_o` low and all strobes low.
- R9: With `cds_mode` = 1, one clamp pulse occurs in each of the first L periods and none in the two flush periods.
- R10: With `cds_mode` = 0, a clamp pulse occurs in period p only when p is below both the dark count D and L. That gives min(D, L) pulses per line, and none when D = 0.
- R11: `cds_mode`, `dark_count` and `line_len` are taken when a line starts. A `line_start` pulse while `busy_o` is high is ignored and does not change the running line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Starts a line when idle |
| cds_mode | input | 1 | 1: clamp every pixel, 0: clamp only dark pixels |
| dark_count | input | CNT_W | Number of leading dark pixels |
| line_len | input | CNT_W | Pixels per line |
| sdata_in | input | 1 | Serial result bit from the digitizer |
| samp_o | output | 1 | Sample strobe |
| clamp_o | output | 1 | Black-level clamp strobe |
| sclk_o | output | 1 | Serial clock to the digitizer |
| word_o | output | WORD_W | Assembled byte, meaningful when word_valid_o is high |
| word_valid_o | output | 1 | One-cycle byte strobe |
| line_done_o | output | 1 | One-cycle end-of-line pulse |
| busy_o | output | 1 | High while a line is running |

## Verification
A wrong in-period phase count moves an edge. It shows up within one pixel period as a sample, clamp or serial clock width, or a sample-to-serial lead, that differs from its parameter. A wrong pixel index shows up by the end of the line as one clamp too many or too few, a byte shifted by one position against the sample it should carry, or a line that runs one period long or short before its done pulse. A wrong bit order or capture point corrupts the very first byte of a line with a non-palindromic pattern.

// File: rtl/ccd_pixel_sequencer.sv
module ccd_pixel_sequencer #(
  parameter int CNT_W   = 12,
  parameter int CLAMP_W = 32,
  parameter int SEP_W   = 6,
  parameter int SAMP_W  = 52,
  parameter int LEAD_W  = 6,
  parameter int HALF_W  = 6,
  parameter int PIX_CYC = 200,
  parameter int WORD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              cds_mode,
  input  logic [CNT_W-1:0]  dark_count,
  input  logic [CNT_W-1:0]  line_len,
  input  logic              sdata_in,
  output logic              samp_o,
  output logic              clamp_o,
  output logic              sclk_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              line_done_o,
  output logic              busy_o
);
  localparam int SAMP_ON  = CLAMP_W + SEP_W;
  localparam int SAMP_OFF = SAMP_ON + SAMP_W;
  localparam int SCLK_ON  = SAMP_OFF + LEAD_W;
  localparam int PERIOD   = 2 * HALF_W;
  localparam int SCLK_OFF = SCLK_ON + PERIOD * WORD_W;
  localparam int PC_W     = $clog2(PIX_CYC);
  localparam int PX_W     = CNT_W + 1;

  logic [PC_W-1:0]   pc_q;
  logic [PX_W-1:0]   px_q;
  logic [CNT_W-1:0]  len_q, dark_q;
  logic              cds_q, run_q;
  logic [WORD_W-1:0] sh_q;

  int   pci, rel;
  logic clamp_px, samp_d, clamp_d, sclk_d, grab, last_bit, pix_end, last_px;

  assign pci      = int'(pc_q);
  assign rel      = pci - SCLK_ON;
  assign clamp_px = cds_q ? (px_q < {1'b0, len_q})
                          : (px_q < {1'b0, dark_q}) && (px_q < {1'b0, len_q});
  assign samp_d   = run_q && pci >= SAMP_ON && pci < SAMP_OFF;
  assign clamp_d  = run_q && clamp_px && pci < CLAMP_W;
  assign sclk_d   = run_q && pci >= SCLK_ON && pci < SCLK_OFF && (rel % PERIOD) < HALF_W;
  assign grab     = sclk_d && !sclk_o;
  assign last_bit = (rel / PERIOD) == WORD_W - 1;
  assign pix_end  = run_q && pci == PIX_CYC - 1;
  assign last_px  = px_q == ({1'b0, len_q} + PX_W'(1));
  assign word_o   = sh_q;
  assign busy_o   = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0; px_q <= '0; len_q <= '0; dark_q <= '0; cds_q <= 1'b0; run_q <= 1'b0;
      sh_q <= '0; samp_o <= 1'b0; clamp_o <= 1'b0; sclk_o <= 1'b0;
      word_valid_o <= 1'b0; line_done_o <= 1'b0;
    end else begin
      samp_o       <= samp_d;
      clamp_o      <= clamp_d;
      sclk_o       <= sclk_d;
      word_valid_o <= grab && last_bit && (px_q >= PX_W'(2));
      line_done_o  <= pix_end && last_px;
      if (grab) sh_q <= {sh_q[WORD_W-2:0], sdata_in};
      if (!run_q) begin
        if (line_start) begin
          run_q  <= 1'b1;
          pc_q   <= '0;
          px_q   <= '0;
          len_q  <= line_len;
          dark_q <= dark_count;
          cds_q  <= cds_mode;
        end
      end else if (pix_end) begin
        pc_q <= '0;
        if (last_px) run_q <= 1'b0;
        else         px_q  <= px_q + PX_W'(1);
      end else begin
        pc_q <= pc_q + PC_W'(1);
      end
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(clamp_o && samp_o)); // R3
  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    samp_o |-> !sclk_o); // R5
  AST_SCLK_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> !$past(samp_o)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_done_o |-> !busy_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !samp_o && !clamp_o && !sclk_o); // R8
endmodule

// File: tb/ccd_pixel_sequencer_tb.sv
module ccd_pixel_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12, CLAMP_W = 32, SEP_W = 6, SAMP_W = 52;
  localparam int LEAD_W = 6, HALF_W = 6, PIX_CYC = 200, L_MAX = 16;

  logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0, cds_mode = 1'b0;
  logic [CNT_W-1:0] dark_count = '0, line_len = '0;
  logic sdata;
  logic samp, clamp, sclk, wvalid, done, busy;
  logic [7:0] word;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_pixel_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .cds_mode(cds_mode),
    .dark_count(dark_count), .line_len(line_len), .sdata_in(sdata),
    .samp_o(samp), .clamp_o(clamp), .sclk_o(sclk), .word_o(word),
    .word_valid_o(wvalid), .line_done_o(done), .busy_o(busy));

  int total = 0, bad = 0;
  logic [7:0] pat [L_MAX];
  logic [7:0] sreg = 8'h00;
  assign sdata = sreg[7];

  int cyc = 0, sidx = 0, t_sr = 0, t_sf = 0, t_cr = 0, t_cf = 0, t_kr = 0;
  bit have_sr = 0, first = 0, cpend = 0;
  logic p_samp = 0, p_clamp = 0, p_sclk = 0;
  int v_period = 0, v_samp = 0, v_clamp = 0, v_gap = 0, v_overlap = 0;
  int v_lead = 0, v_sclk = 0, v_quiet = 0, v_word = 0;
  int samp_l = 0, clamp_l = 0, rise_l = 0, wcnt_l = 0, done_cnt = 0;
  int last_samps = 0, last_clamps = 0, last_rises = 0, last_words = 0;
  logic [7:0] bad_act = 0, bad_exp = 0;

  // digitizer model and timing monitor, sampled mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (samp && !p_samp) begin
        samp_l++;
        if (have_sr && cyc - t_sr != PIX_CYC) v_period++;
        have_sr = 1; t_sr = cyc;
        if (cpend) begin if (cyc - t_cf != SEP_W) v_gap++; cpend = 0; end
      end
      if (!samp && p_samp) begin
        if (cyc - t_sr != SAMP_W) v_samp++;
        t_sf = cyc; first = 1;
        sreg = (sidx >= 2) ? pat[sidx-2] : 8'h3C;
        sidx++;
      end
      if (clamp && !p_clamp) begin t_cr = cyc; clamp_l++; end
      if (clamp && samp) v_overlap++;
      if (!clamp && p_clamp) begin
        if (cyc - t_cr != CLAMP_W) v_clamp++;
        t_cf = cyc; cpend = 1;
      end
      if (sclk && !p_sclk) begin
        rise_l++;
        if (first) begin if (cyc - t_sf != LEAD_W) v_lead++; first = 0; end
        t_kr = cyc;
        sreg = {sreg[6:0], 1'b0};
      end
      if (sclk && (samp || p_samp)) v_quiet++;
      if (!sclk && p_sclk && cyc - t_kr != HALF_W) v_sclk++;
      if (wvalid) begin
        if (wcnt_l < L_MAX && word != pat[wcnt_l]) begin
          v_word++; bad_act = word; bad_exp = pat[wcnt_l];
        end
        wcnt_l++;
      end
      if (done) begin
        done_cnt++;
        last_samps = samp_l; last_clamps = clamp_l; last_rises = rise_l; last_words = wcnt_l;
        samp_l = 0; clamp_l = 0; rise_l = 0; wcnt_l = 0; sidx = 0; have_sr = 0; cpend = 0;
      end
    end
    p_samp = samp; p_clamp = clamp; p_sclk = sclk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input bit cds, input int dark, input int len);
    @(posedge clk); #1;
    cds_mode = cds; dark_count = CNT_W'(dark); line_len = CNT_W'(len); line_start = 1'b1;
    @(posedge clk); #1;
    line_start = 1'b0;
  endtask

  task automatic run_line(input bit cds, input int dark, input int len, input int seed,
                          input bit restart);
    int d0, w;
    for (int i = 0; i < L_MAX; i++) pat[i] = 8'((seed * 53 + i * 29) ^ (i << 4));
    d0 = done_cnt;
    pulse_start(cds, dark, len);
    if (restart) begin
      repeat (300) @(posedge clk);
      pulse_start(!cds, 1, len + 3);
    end
    w = 0;
    while (done_cnt == d0 && w < 20000) begin @(posedge clk); w++; end
    check(w < 20000, "R8 watchdog", w, 20000);
    repeat (PIX_CYC + 20) @(posedge clk);
    #2;
    check(done_cnt == d0 + 1, "R8 one done per line", done_cnt - d0, 1);
    check(!busy && !samp && !clamp && !sclk, "R8 idle after done", int'(busy), 0);
    check(last_samps == len + 2, "R2 sample pulses per line", last_samps, len + 2);
    check(last_rises == 8 * (len + 2), "R4 serial clock rises", last_rises, 8 * (len + 2));
    check(last_words == len, "R7 bytes per line", last_words, len);
    check(last_clamps == (cds ? len : (dark < len ? dark : len)),
          cds ? "R9 clamp count" : "R10 clamp count", last_clamps,
          cds ? len : (dark < len ? dark : len));
    check(v_word == 0, "R6 R7 byte content/order", int'(bad_act), int'(bad_exp));
    check(v_period == 0 && v_samp == 0, "R2 period/width", v_period + v_samp, 0);
    check(v_clamp == 0 && v_gap == 0 && v_overlap == 0, "R3 clamp timing",
          v_clamp + v_gap + v_overlap, 0);
    check(v_lead == 0 && v_sclk == 0, "R4 serial timing", v_lead + v_sclk, 0);
    check(v_quiet == 0, "R5 quiet window", v_quiet, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!samp && !clamp && !sclk && !wvalid && !done && !busy, "R1 reset state",
          int'({samp, clamp, sclk, wvalid, done, busy}), 0);
  endtask

  task automatic t_cds_line;
    run_line(1'b1, 0, 4, 7, 1'b0);
  endtask

  task automatic t_dark_line;
    run_line(1'b0, 2, 5, 11, 1'b0);
  endtask

  task automatic t_bit_order;
    int d0, w;
    pat[0] = 8'h80; pat[1] = 8'h01; pat[2] = 8'hC3;
    for (int i = 3; i < L_MAX; i++) pat[i] = 8'(i);
    d0 = done_cnt;
    pulse_start(1'b1, 0, 3);
    w = 0;
    while (done_cnt == d0 && w < 20000) begin @(posedge clk); w++; end
    #2;
    check(v_word == 0, "R6 MSB first", int'(bad_act), int'(bad_exp));
    check(last_words == 3, "R7 short line bytes", last_words, 3);
  endtask

  task automatic t_no_dark;
    run_line(1'b0, 0, 3, 23, 1'b0);
  endtask

  task automatic t_dark_exceeds;
    run_line(1'b0, 9, 3, 31, 1'b0);
  endtask

  task automatic t_busy_ignore;
    run_line(1'b1, 0, 4, 41, 1'b1); // R11: restart request with new settings ignored
    check(last_samps == 6, "R11 line length kept", last_samps, 6);
  endtask

  initial begin
    t_reset();
    t_cds_line();
    t_dark_line();
    t_bit_order();
    t_no_dark();
    t_dark_exceeds();
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL R8 global watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule